// File: doc/BRIEF.md
# In-Order Completion Reorder Buffer

This block tracks every dispatched instruction from dispatch until it leaves the machine, so that results are written to architected state strictly in program order. Each cycle the dispatch stage may hand over a group of zero to four instructions. Each instruction comes with the rename tag of its destination, and the buffer gives back consecutive entry numbers. Execution units later report against an entry number that the instruction has finished, and may flag a fault or a mispredicted branch. The buffer holds sixteen entries in a circular arrangement.

From the oldest entry onward, the retire logic commits up to four finished entries per clock. For each committed entry it raises a commit lane carrying that entry's rename tag, so the rename storage can copy the value into the architected register. An unfinished entry stops retirement, so any unresolved branch holds back every result behind it. A mispredict report cuts off every younger entry at once and reports them on a kill mask, so their rename results can be dropped. A faulting entry is taken when retirement reaches it. Neither it nor anything younger is committed, which keeps the exception model precise.

Top module: `inorder_rob`

## Requirements
- R1: After reset the buffer is empty: alloc_id is 0, no commit lane is valid, no flush is signalled, and a four-instruction group is accepted.
- R2: An accepted group of disp_cnt instructions (0 to 4) takes consecutive entry numbers starting at alloc_id, with lane 0 oldest. Lane j's tag is disp_tags[j*5+4:j*5]. From the next cycle alloc_id has advanced by disp_cnt, modulo 16.
- R3: disp_stall is high and nothing is allocated when disp_cnt exceeds 16 minus the occupancy at the start of the cycle. Entries retiring in that same cycle are not yet counted as free.
- R4: An entry commits only when it has finished and every older entry commits in the same or an earlier cycle. Commit lane 0 is the oldest. Valid lanes are contiguous from lane 0, and lane l carries its tag on cmt_tag[l*5+4:l*5].
- R5: At most four entries commit per cycle. Further finished entries commit in the following cycles.
- R6: A report (rep_vld lane p, entry on rep_id[p*4+3:p*4]) that names an entry outside the occupied range is ignored. It raises no flush and does not move alloc_id.
- R7: A report with rep_mispred set marks the branch as finished and, in the same cycle, raises mp_flush with mp_id set to the branch. kill_mask has bit n set for each occupied entry n that is younger than the branch. From the next cycle alloc_id is the branch entry plus one. The branch and the older entries stay and commit later.
- R8: When several mispredict reports arrive in one cycle, the oldest branch is the one flushed.
- R9: A report with rep_fault set is taken in the cycle where that entry is the first non-committing one in the retire window. In that cycle exc_flush is high, exc_id names the entry, and older lanes still commit. The entry and all younger entries are set in kill_mask and none of them commit. The buffer is empty on the next cycle, with alloc_id equal to exc_id.
- R10: When a fault is taken in the same cycle as a mispredict report, the fault wins. mp_flush stays low and kill_mask follows R9.
- R11: disp_stall is high in every cycle in which mp_flush or exc_flush is high.
- R12: A completion reported in one cycle can commit at the earliest in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_cnt | input | 3 | Number of instructions offered this cycle (0..4) |
| disp_tags | input | 20 | Destination rename tag per dispatch lane, 5 bits each |
| disp_stall | output | 1 | Group refused this cycle |
| alloc_id | output | 4 | Entry number given to dispatch lane 0 |
| rep_vld | input | 2 | Completion report valid per report port |
| rep_id | input | 8 | Entry number per report port, 4 bits each |
| rep_fault | input | 2 | Report carries a fault |
| rep_mispred | input | 2 | Report is a mispredicted branch |
| cmt_vld | output | 4 | Commit lane valid, lane 0 oldest |
| cmt_tag | output | 20 | Rename tag per commit lane |
| mp_flush | output | 1 | Mispredict flush this cycle |
| mp_id | output | 4 | Entry of the flushing branch |
| exc_flush | output | 1 | Fault taken this cycle |
| exc_id | output | 4 | Entry of the faulting instruction |
| kill_mask | output | 16 | Entries discarded this cycle, bit n for entry n |

## Verification
Retirement, mispredict flush and fault capture can all fall in one cycle. The bench finishes an older entry while a younger branch reports a mispredict, and it places a fault at the oldest entry while a younger branch mispredicts. In each case it checks, in that one cycle, which lanes commit, which flush wins, and the exact kill mask, and then checks alloc_id on the next cycle. The mispredict sweep starts with the oldest entry at 12, so the age arithmetic is judged across the wrap from entry 15 to entry 0.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
  // Distance from the oldest entry to entry idx around the ring (0 = oldest).
  function automatic int ring_age(int idx, int head, int depth);
    return (idx - head + depth) % depth;
  endfunction

  // Entries still free given the current occupancy.
  function automatic int free_slots(int occ, int depth);
    return depth - occ;
  endfunction
endpackage

// File: rtl/rob_store.sv
`timescale 1ns/1ps
module rob_store #(
  parameter int DEPTH = 16,
  parameter int TAGW  = 5,
  parameter int LANES = 4,
  parameter int NFIN  = 2,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] alloc_we,
  input  logic [PW-1:0]    alloc_idx [LANES],
  input  logic [TAGW-1:0]  alloc_tag [LANES],
  input  logic [NFIN-1:0]  done_we,
  input  logic [PW-1:0]    done_idx [NFIN],
  input  logic [NFIN-1:0]  done_fault,
  output logic [DEPTH-1:0] done_q,
  output logic [DEPTH-1:0] fault_q,
  output logic [TAGW-1:0]  tag_q [DEPTH]
);
  // Completion writes first, allocation after: a fresh entry always starts clean.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= '0;
      fault_q <= '0;
      for (int e = 0; e < DEPTH; e++) tag_q[e] <= '0;
    end else begin
      for (int p = 0; p < NFIN; p++) begin
        if (done_we[p]) begin
          done_q[done_idx[p]] <= 1'b1;
          if (done_fault[p]) fault_q[done_idx[p]] <= 1'b1;
        end
      end
      for (int l = 0; l < LANES; l++) begin
        if (alloc_we[l]) begin
          done_q[alloc_idx[l]]  <= 1'b0;
          fault_q[alloc_idx[l]] <= 1'b0;
          tag_q[alloc_idx[l]]   <= alloc_tag[l];
        end
      end
    end
  end
endmodule

// File: rtl/rob_retire.sv
`timescale 1ns/1ps
module rob_retire #(
  parameter int DEPTH = 16,
  parameter int TAGW  = 5,
  parameter int LANES = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1,
  localparam int NW   = $clog2(LANES + 1)
) (
  input  logic [PW-1:0]         head_idx,
  input  logic [CW-1:0]         occ,
  input  logic [DEPTH-1:0]      done_q,
  input  logic [DEPTH-1:0]      fault_q,
  input  logic [TAGW-1:0]       tag_q [DEPTH],
  output logic [LANES-1:0]      cmt_vld,
  output logic [LANES*TAGW-1:0] cmt_tag,
  output logic [NW-1:0]         nret,
  output logic                  fault_take,
  output logic [PW-1:0]         fault_idx
);
  logic [PW-1:0] lane_idx [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_idx[l] = head_idx + PW'(l);
    assign cmt_tag[l*TAGW +: TAGW] = tag_q[lane_idx[l]];
  end

  // Scan from the oldest entry; the first unfinished or faulting entry ends the run.
  logic blocked;
  always_comb begin
    blocked    = 1'b0;
    cmt_vld    = '0;
    nret       = '0;
    fault_take = 1'b0;
    fault_idx  = head_idx;
    for (int l = 0; l < LANES; l++) begin
      if (!blocked) begin
        if (l >= int'(occ) || !done_q[lane_idx[l]]) begin
          blocked = 1'b1;
        end else if (fault_q[lane_idx[l]]) begin
          blocked    = 1'b1;
          fault_take = 1'b1;
          fault_idx  = lane_idx[l];
        end else begin
          cmt_vld[l] = 1'b1;
          nret       = nret + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rob_flush.sv
`timescale 1ns/1ps
module rob_flush
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  parameter int NFIN  = 2,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1,
  localparam int NW   = $clog2(LANES + 1)
) (
  input  logic [PW-1:0]    head_idx,
  input  logic [CW-1:0]    occ,
  input  logic [NW-1:0]    nret,
  input  logic [NFIN-1:0]  rep_vld,
  input  logic [PW-1:0]    rep_idx [NFIN],
  input  logic [NFIN-1:0]  rep_mp,
  input  logic             fault_take,
  output logic [NFIN-1:0]  rep_live,
  output logic             mp_flush,
  output logic [PW-1:0]    mp_idx,
  output logic [PW-1:0]    mp_age,
  output logic [DEPTH-1:0] kill_mask
);
  int rep_age [NFIN];
  int ent_age [DEPTH];

  for (genvar p = 0; p < NFIN; p++) begin : g_rep
    assign rep_age[p] = ring_age(int'(rep_idx[p]), int'(head_idx), DEPTH);
  end
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    assign ent_age[e] = ring_age(e, int'(head_idx), DEPTH);
  end

  int   best;
  logic mp_hit;
  always_comb begin
    best     = DEPTH;
    mp_idx   = head_idx;
    rep_live = '0;
    for (int p = 0; p < NFIN; p++) begin
      if (rep_vld[p] && rep_age[p] < int'(occ)) begin
        rep_live[p] = 1'b1;
        if (rep_mp[p] && rep_age[p] < best) begin
          best   = rep_age[p];
          mp_idx = rep_idx[p];
        end
      end
    end
    mp_hit   = best < DEPTH;
    mp_flush = mp_hit && !fault_take;
    mp_age   = PW'(best);
    for (int e = 0; e < DEPTH; e++) begin
      if (fault_take)
        kill_mask[e] = ent_age[e] >= int'(nret) && ent_age[e] < int'(occ);
      else if (mp_flush)
        kill_mask[e] = ent_age[e] > best && ent_age[e] < int'(occ);
      else
        kill_mask[e] = 1'b0;
    end
  end
endmodule

// File: rtl/inorder_rob.sv
`timescale 1ns/1ps
module inorder_rob
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TAGW  = 5,
  parameter int LANES = 4,
  parameter int NFIN  = 2,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1,
  localparam int NW   = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NW-1:0]         disp_cnt,
  input  logic [LANES*TAGW-1:0] disp_tags,
  output logic                  disp_stall,
  output logic [PW-1:0]         alloc_id,
  input  logic [NFIN-1:0]       rep_vld,
  input  logic [NFIN*PW-1:0]    rep_id,
  input  logic [NFIN-1:0]       rep_fault,
  input  logic [NFIN-1:0]       rep_mispred,
  output logic [LANES-1:0]      cmt_vld,
  output logic [LANES*TAGW-1:0] cmt_tag,
  output logic                  mp_flush,
  output logic [PW-1:0]         mp_id,
  output logic                  exc_flush,
  output logic [PW-1:0]         exc_id,
  output logic [DEPTH-1:0]      kill_mask
);
  // Pointers carry one wrap bit so that full and empty differ.
  logic [CW-1:0]    head_q, tail_q, head_n, tail_n;
  logic [CW-1:0]    occ;
  int               free_cnt;
  logic             flush_now, accept;
  logic [NW-1:0]    nret;
  logic [PW-1:0]    mp_age;
  logic [NFIN-1:0]  rep_live;
  logic [DEPTH-1:0] done_q, fault_q;
  logic [TAGW-1:0]  tag_q [DEPTH];
  logic [LANES-1:0] alloc_we;
  logic [PW-1:0]    alloc_idx [LANES];
  logic [TAGW-1:0]  alloc_tag [LANES];
  logic [PW-1:0]    rep_idx [NFIN];

  assign occ       = tail_q - head_q;
  assign free_cnt  = free_slots(int'(occ), DEPTH);
  assign flush_now = mp_flush || exc_flush;
  assign disp_stall = (int'(disp_cnt) > free_cnt) || flush_now;
  assign accept    = !disp_stall;
  assign alloc_id  = tail_q[PW-1:0];

  for (genvar l = 0; l < LANES; l++) begin : g_alloc
    assign alloc_we[l]  = accept && (l < int'(disp_cnt));
    assign alloc_idx[l] = tail_q[PW-1:0] + PW'(l);
    assign alloc_tag[l] = disp_tags[l*TAGW +: TAGW];
  end
  for (genvar p = 0; p < NFIN; p++) begin : g_rep
    assign rep_idx[p] = rep_id[p*PW +: PW];
  end

  rob_store #(.DEPTH(DEPTH), .TAGW(TAGW), .LANES(LANES), .NFIN(NFIN)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_we   (alloc_we),
    .alloc_idx  (alloc_idx),
    .alloc_tag  (alloc_tag),
    .done_we    (rep_live),
    .done_idx   (rep_idx),
    .done_fault (rep_fault),
    .done_q     (done_q),
    .fault_q    (fault_q),
    .tag_q      (tag_q)
  );

  rob_retire #(.DEPTH(DEPTH), .TAGW(TAGW), .LANES(LANES)) u_retire (
    .head_idx   (head_q[PW-1:0]),
    .occ        (occ),
    .done_q     (done_q),
    .fault_q    (fault_q),
    .tag_q      (tag_q),
    .cmt_vld    (cmt_vld),
    .cmt_tag    (cmt_tag),
    .nret       (nret),
    .fault_take (exc_flush),
    .fault_idx  (exc_id)
  );

  rob_flush #(.DEPTH(DEPTH), .LANES(LANES), .NFIN(NFIN)) u_flush (
    .head_idx   (head_q[PW-1:0]),
    .occ        (occ),
    .nret       (nret),
    .rep_vld    (rep_vld),
    .rep_idx    (rep_idx),
    .rep_mp     (rep_mispred),
    .fault_take (exc_flush),
    .rep_live   (rep_live),
    .mp_flush   (mp_flush),
    .mp_idx     (mp_id),
    .mp_age     (mp_age),
    .kill_mask  (kill_mask)
  );

  always_comb begin
    head_n = head_q + CW'(nret);
    if (exc_flush)     tail_n = head_n;
    else if (mp_flush) tail_n = head_q + CW'(mp_age) + CW'(1);
    else if (accept)   tail_n = tail_q + CW'(disp_cnt);
    else               tail_n = tail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
    end
  end

  // Occupancy never exceeds the ring size.
  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  // Accepted groups grow occupancy exactly by the group size less retirements.
  assert_alloc_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_stall |=> occ == $past(occ) + CW'($past(disp_cnt)) - CW'($past(nret)));

  // Commit lanes form an unbroken run starting at lane 0.
  assert_inorder_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_vld & (cmt_vld + 1'b1)) == '0);

  // No more commits than occupied entries.
  assert_retire_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cmt_vld) <= int'(occ));

  // After a mispredict, allocation resumes right after the branch.
  assert_mp_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mp_flush |=> alloc_id == PW'($past(mp_id) + 1'b1));

  // The faulting entry itself is discarded, and the ring is empty afterwards.
  assert_fault_killed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_flush |-> kill_mask[exc_id]);
  assert_exc_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_flush |=> occ == '0);
endmodule

// File: tb/inorder_rob_bench.sv
`timescale 1ns/100ps
module inorder_rob_bench;
  localparam int DEPTH = 16;
  localparam int TAGW  = 5;
  localparam int LANES = 4;
  localparam int NFIN  = 2;
  localparam int PW    = 4;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [2:0]            disp_cnt;
  logic [LANES*TAGW-1:0] disp_tags;
  logic                  disp_stall;
  logic [PW-1:0]         alloc_id;
  logic [NFIN-1:0]       rep_vld;
  logic [NFIN*PW-1:0]    rep_id;
  logic [NFIN-1:0]       rep_fault;
  logic [NFIN-1:0]       rep_mispred;
  logic [LANES-1:0]      cmt_vld;
  logic [LANES*TAGW-1:0] cmt_tag;
  logic                  mp_flush;
  logic [PW-1:0]         mp_id;
  logic                  exc_flush;
  logic [PW-1:0]         exc_id;
  logic [DEPTH-1:0]      kill_mask;

  int  nchk = 0;
  int  nfail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  inorder_rob u_inorder_rob (
    .clk(clk), .rst_n(rst_n), .disp_cnt(disp_cnt), .disp_tags(disp_tags),
    .disp_stall(disp_stall), .alloc_id(alloc_id), .rep_vld(rep_vld), .rep_id(rep_id),
    .rep_fault(rep_fault), .rep_mispred(rep_mispred), .cmt_vld(cmt_vld), .cmt_tag(cmt_tag),
    .mp_flush(mp_flush), .mp_id(mp_id), .exc_flush(exc_flush), .exc_id(exc_id),
    .kill_mask(kill_mask)
  );

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_cnt = '0; disp_tags = '0; rep_vld = '0; rep_id = '0;
    rep_fault = '0; rep_mispred = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic settle();
    #0.5;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic disp(int n, int tag0);
    disp_cnt = 3'(n);
    for (int j = 0; j < n; j++) disp_tags[j*TAGW +: TAGW] = TAGW'((tag0 + j) % 32);
  endtask

  task automatic rep(int p, int id, bit f, bit m);
    rep_vld[p] = 1'b1;
    rep_id[p*PW +: PW] = PW'(id % DEPTH);
    rep_fault[p] = f;
    rep_mispred[p] = m;
  endtask

  function automatic int lane_tag(int l);
    return int'(cmt_tag[l*TAGW +: TAGW]);
  endfunction

  // Bring the oldest entry to position 12 by filling and draining three groups.
  task automatic advance_head12();
    for (int g = 0; g < 3; g++) begin
      disp(4, g * 4); tick();
      rep(0, g*4 + 2, 0, 0); rep(1, g*4 + 3, 0, 0); tick();
      rep(0, g*4, 0, 0); rep(1, g*4 + 1, 0, 0); tick();
      tick();
    end
  endtask

  initial begin
    idle();
    // Reset state
    do_reset();
    disp_cnt = 3'd4;
    settle();
    chk("R1 alloc_id", int'(alloc_id), 0);
    chk("R1 cmt_vld", int'(cmt_vld), 0);
    chk("R1 flush", int'(mp_flush) + int'(exc_flush), 0);
    chk("R1 stall", int'(disp_stall), 0);
    idle();

    // Sweep over every completion pattern of four entries (R4, R12, R2)
    for (int m = 0; m < 16; m++) begin
      int run;
      do_reset();
      disp(4, m * 4);
      tick();
      settle();
      chk("R2 alloc_id advance", int'(alloc_id), 4);
      if (m[2]) rep(0, 2, 0, 0);
      if (m[3]) rep(1, 3, 0, 0);
      tick();
      settle();
      chk("R4 no commit while entry0 open", int'(cmt_vld), 0);
      if (m[0]) rep(0, 0, 0, 0);
      if (m[1]) rep(1, 1, 0, 0);
      settle();
      chk("R12 report not visible same cycle", int'(cmt_vld), 0);
      tick();
      settle();
      run = 0;
      for (int b = 0; b < 4; b++) begin
        if (((m >> b) & 1) == 1 && run == b) run++;
      end
      chk("R4 commit run", int'(cmt_vld), (1 << run) - 1);
      if (run > 0) begin
        chk("R4 lane0 tag", lane_tag(0), (m * 4) % 32);
        chk("R4 last lane tag", lane_tag(run - 1), (m * 4 + run - 1) % 32);
      end
    end

    // Four per cycle with eight finished entries (R5)
    do_reset();
    disp(4, 0); tick();
    disp(4, 4); tick();
    for (int k = 3; k >= 0; k--) begin
      rep(0, 2*k + 1, 0, 0); rep(1, 2*k, 0, 0); tick();
    end
    settle();
    chk("R5 first four", int'(cmt_vld), 15);
    chk("R5 first tag", lane_tag(3), 3);
    tick(); settle();
    chk("R5 second four", int'(cmt_vld), 15);
    chk("R5 second tag", lane_tag(0), 4);
    tick(); settle();
    chk("R5 drained", int'(cmt_vld), 0);

    // Full ring and free-count boundary (R3)
    do_reset();
    for (int g = 0; g < 4; g++) begin disp(4, g * 4); tick(); end
    settle();
    chk("R2 alloc_id wraps", int'(alloc_id), 0);
    for (int c = 0; c <= 4; c++) begin
      disp_cnt = 3'(c); settle();
      chk("R3 full stall", int'(disp_stall), int'(c > 0));
    end
    idle();
    rep(0, 0, 0, 0); tick(); settle();
    chk("R3 retire cycle commit", int'(cmt_vld), 1);
    disp_cnt = 3'd1; settle();
    chk("R3 retiring slot not yet free", int'(disp_stall), 1);
    tick();
    for (int c = 0; c <= 4; c++) begin
      disp_cnt = 3'(c); settle();
      chk("R3 one free slot", int'(disp_stall), int'(c > 1));
    end
    idle();
    disp(1, 9); tick(); settle();
    chk("R2 single accepted", int'(alloc_id), 1);

    // Reports outside the occupied range (R6)
    do_reset();
    disp(2, 0); tick();
    rep(0, 6, 0, 1); rep(1, 2, 1, 0); settle();
    chk("R6 stray mispredict", int'(mp_flush), 0);
    tick(); settle();
    chk("R6 alloc_id unchanged", int'(alloc_id), 2);
    disp(4, 2); tick();
    rep(0, 0, 0, 0); rep(1, 1, 0, 0); tick(); settle();
    chk("R6 commit older two", int'(cmt_vld), 3);
    tick();
    rep(0, 2, 0, 0); tick(); settle();
    chk("R6 stale fault ignored", int'(exc_flush), 0);
    chk("R6 entry2 commits", int'(cmt_vld), 1);

    // Mispredict flush with concurrent older completion (R7, R11)
    do_reset();
    disp(4, 0); tick(); disp(4, 4); tick();
    rep(0, 2, 0, 1); rep(1, 0, 0, 0); disp_cnt = 3'd1; settle();
    chk("R7 mp_flush", int'(mp_flush), 1);
    chk("R7 mp_id", int'(mp_id), 2);
    chk("R7 kill_mask", int'(kill_mask), 'hF8);
    chk("R11 stall on flush", int'(disp_stall), 1);
    tick(); settle();
    chk("R7 alloc after branch", int'(alloc_id), 3);
    chk("R7 older commits", int'(cmt_vld), 1);
    tick();
    rep(0, 1, 0, 0); tick(); settle();
    chk("R7 branch commits", int'(cmt_vld), 3);
    chk("R7 branch tag", lane_tag(1), 2);

    // Oldest of two mispredicts (R8)
    do_reset();
    disp(4, 0); tick(); disp(4, 4); tick();
    rep(0, 5, 0, 1); rep(1, 1, 0, 1); settle();
    chk("R8 oldest id", int'(mp_id), 1);
    chk("R8 kill_mask", int'(kill_mask), 'hFC);
    tick(); settle();
    chk("R8 alloc_id", int'(alloc_id), 2);

    // Mispredict position sweep across the ring wrap (R7)
    for (int k = 0; k < 8; k++) begin
      int expm;
      do_reset();
      advance_head12();
      disp(4, 16); tick(); disp(4, 20); tick();
      rep(0, 12 + k, 0, 1); settle();
      expm = 0;
      for (int e = k + 1; e < 8; e++) expm |= 1 << ((12 + e) % 16);
      chk("R7 wrap flush", int'(mp_flush), 1);
      chk("R7 wrap kill_mask", int'(kill_mask), expm);
      tick(); settle();
      chk("R7 wrap alloc_id", int'(alloc_id), (13 + k) % 16);
    end

    // Fault after an older completion in the same window (R9)
    do_reset();
    disp(4, 8); tick();
    rep(0, 0, 0, 0); rep(1, 1, 1, 0); tick(); settle();
    chk("R9 exc_flush", int'(exc_flush), 1);
    chk("R9 exc_id", int'(exc_id), 1);
    chk("R9 older still commits", int'(cmt_vld), 1);
    chk("R9 kill_mask", int'(kill_mask), 'hE);
    tick(); settle();
    chk("R9 alloc_id at fault", int'(alloc_id), 1);
    chk("R9 nothing commits", int'(cmt_vld), 0);
    disp_cnt = 3'd4; settle();
    chk("R9 ring empty", int'(disp_stall), 0);
    idle();

    // Fault and mispredict together (R10)
    do_reset();
    disp(4, 0); tick();
    rep(0, 0, 1, 0); tick();
    rep(1, 2, 0, 1); settle();
    chk("R10 fault wins", int'(exc_flush), 1);
    chk("R10 mp suppressed", int'(mp_flush), 0);
    chk("R10 kill_mask", int'(kill_mask), 'hF);
    tick(); settle();
    chk("R10 alloc_id", int'(alloc_id), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule